// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block maps a 5-bit byte address from the virtual space onto a 4-bit physical address. It uses a page table of eight entries held in registers. A page is four bytes, so the low two address bits are an offset that passes straight through. The upper three bits pick a virtual page, and that page resolves to one of four physical frames. Each table entry stores a frame number, a valid flag and a dirty flag. When a page is resident, the translated address comes back one cycle after the request is taken.

A reference to a page that is not resident starts an in-hardware fault sequence. The unit first takes the lowest-numbered frame that has never been allocated. When every frame is in use, it evicts the least recently used one. If the evicted page is dirty, the unit asks a backing-store controller to write it back. It then clears the old page's entry, requests the fill of the new page, and installs the new mapping. The response to the faulting request carries a fault flag. New requests are held off until the sequence ends.

The controller is one state machine with five states. The state IDLE accepts requests and answers hits. SELECT picks a free frame or a victim. WRITEBACK waits for the write-back acknowledge. FILL waits for the fill acknowledge. UPDATE installs the entry and launches the response. The transitions are as follows:
- IDLE to IDLE on a hit.
- IDLE to SELECT on a miss.
- SELECT to FILL when a free frame exists or the victim is clean.
- SELECT to WRITEBACK when the victim is dirty.
- WRITEBACK to FILL on `wb_done`.
- FILL to UPDATE on `fill_done`.
- UPDATE to IDLE unconditionally.

Top module: `pgxlat_unit`

## Requirements
- R1: After reset every table entry is invalid and no frame is allocated. `req_ready` is 1 and `rsp_valid`, `wb_valid` and `fill_valid` are 0.
- R2: A request taken in IDLE for a valid page gives `rsp_valid`=1 and `rsp_fault`=0 in the next cycle, with `rsp_paddr` = {frame[1:0], vaddr[1:0]}.
- R3: A request for an invalid page starts the fault sequence. Its response has `rsp_fault`=1 and `rsp_paddr` = {installed frame, offset}. That response appears exactly two cycles after the cycle in which `fill_done` is seen during FILL.
- R4: While any frame is unallocated, a fault takes the lowest-numbered free frame and no write-back occurs.
- R5: Once a page is mapped, every later reference to it translates to the same frame until it is evicted.
- R6: With all frames allocated, the victim is the frame least recently touched. Both hits and fills count as touches.
- R7: A dirty victim causes WRITEBACK. There `wb_valid`=1 with `wb_vpn` and `wb_frame` naming the victim, and these are held steady until `wb_done`. A clean victim never raises `wb_valid`.
- R8: The victim's entry is invalidated, so the next reference to the evicted page faults.
- R9: A write hit sets the page's dirty flag and a read leaves it unchanged. A write that faults installs its page dirty. Dirtiness is seen later as a write-back on eviction.
- R10: In FILL, `fill_valid`=1 with `fill_vpn` and `fill_frame` naming the incoming page and its frame, held steady until `fill_done`.
- R11: `req_ready` is 0 from the cycle after a missing request is taken until the fault response is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can take a request (IDLE) |
| req_vaddr | input | 5 | Virtual byte address |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 4 | Translated physical address |
| rsp_fault | output | 1 | Response came through the fault sequence |
| wb_valid | output | 1 | Write-back requested |
| wb_vpn | output | 3 | Virtual page being written back |
| wb_frame | output | 2 | Frame being written back |
| wb_done | input | 1 | Write-back finished |
| fill_valid | output | 1 | Fill requested |
| fill_vpn | output | 3 | Virtual page to load |
| fill_frame | output | 2 | Frame to load into |
| fill_done | input | 1 | Fill finished |

## Verification
A hit response is due in the cycle right after the request edge. The bench drives on falling edges and samples `rsp_valid` at the next falling edge. For a miss, the first sample after the request must show `req_ready` low and no response. The write-back and fill requests are observed for one extra cycle before each acknowledge, which proves they are held steady. The response is then due two falling edges after the `fill_done` edge: one edge for UPDATE and one for the response register. The bench samples the gap cycle as silent and the following one as the fault response. Victim choice is derived in the bench from a hand-traced recency order across a fixed access sequence.

// File: rtl/pgxlat_pkg.sv
package pgxlat_pkg;

    localparam int XL_VA_W  = 5;
    localparam int XL_OFS_W = 2;
    localparam int XL_PA_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_WRITEBACK,
        ST_FILL,
        ST_UPDATE
    } xl_state_e;

endpackage

// File: rtl/pgxlat_table.sv
module pgxlat_table #(
    parameter int VPN_W = 3,
    parameter int PFN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_valid,
    output logic             lk_dirty,
    output logic [PFN_W-1:0] lk_frame,
    input  logic [VPN_W-1:0] rd_vpn,
    output logic             rd_dirty,
    input  logic             dset_en,
    input  logic [VPN_W-1:0] dset_vpn,
    input  logic             inval_en,
    input  logic [VPN_W-1:0] inval_vpn,
    input  logic             inst_en,
    input  logic [VPN_W-1:0] inst_vpn,
    input  logic [PFN_W-1:0] inst_frame,
    input  logic             inst_dirty
);
    localparam int N_PAGE = 1 << VPN_W;

    logic [N_PAGE-1:0] valid_q;
    logic [N_PAGE-1:0] dirty_q;
    logic [PFN_W-1:0]  frame_q [N_PAGE];

    for (genvar p = 0; p < N_PAGE; p++) begin : g_pte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[p] <= 1'b0;
                dirty_q[p] <= 1'b0;
                frame_q[p] <= '0;
            end else if (inst_en && inst_vpn == VPN_W'(p)) begin
                valid_q[p] <= 1'b1;
                dirty_q[p] <= inst_dirty;
                frame_q[p] <= inst_frame;
            end else if (inval_en && inval_vpn == VPN_W'(p)) begin
                valid_q[p] <= 1'b0;
                dirty_q[p] <= 1'b0;
            end else if (dset_en && dset_vpn == VPN_W'(p)) begin
                dirty_q[p] <= 1'b1;
            end
        end
    end

    assign lk_valid = valid_q[lk_vpn];
    assign lk_dirty = dirty_q[lk_vpn];
    assign lk_frame = frame_q[lk_vpn];
    assign rd_dirty = dirty_q[rd_vpn];

    AST_INST_ON_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        inst_en |-> !valid_q[inst_vpn]); // R3
    AST_INVAL_RESIDENT: assert property (@(posedge clk) disable iff (!rst_n)
        inval_en |=> !valid_q[$past(inval_vpn)]); // R8
endmodule

// File: rtl/pgxlat_lru.sv
module pgxlat_lru #(
    parameter int PFN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [PFN_W-1:0] touch_frame,
    output logic [PFN_W-1:0] victim
);
    localparam int N_FRAME = 1 << PFN_W;
    localparam logic [PFN_W-1:0] OLDEST = PFN_W'(N_FRAME - 1);

    logic [PFN_W-1:0]   rank_q [N_FRAME];
    logic [N_FRAME-1:0] is_newest;

    for (genvar f = 0; f < N_FRAME; f++) begin : g_rank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rank_q[f] <= PFN_W'(f);
            end else if (touch_en) begin
                if (touch_frame == PFN_W'(f))
                    rank_q[f] <= '0;
                else if (rank_q[f] < rank_q[touch_frame])
                    rank_q[f] <= rank_q[f] + 1'b1;
            end
        end
        assign is_newest[f] = (rank_q[f] == '0);
    end

    always_comb begin
        victim = '0;
        for (int f = 0; f < N_FRAME; f++)
            if (rank_q[f] == OLDEST) victim = PFN_W'(f);
    end

    AST_ONE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_newest) == 1); // R6
endmodule

// File: rtl/pgxlat_falloc.sv
module pgxlat_falloc #(
    parameter int VPN_W = 3,
    parameter int PFN_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [PFN_W-1:0] alloc_frame,
    input  logic [VPN_W-1:0] alloc_vpn,
    output logic             any_free,
    output logic [PFN_W-1:0] low_free,
    input  logic [PFN_W-1:0] own_frame,
    output logic [VPN_W-1:0] own_vpn
);
    localparam int N_FRAME = 1 << PFN_W;

    logic [N_FRAME-1:0] free_q;
    logic [VPN_W-1:0]   owner_q [N_FRAME];

    for (genvar f = 0; f < N_FRAME; f++) begin : g_frame
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                free_q[f]  <= 1'b1;
                owner_q[f] <= '0;
            end else if (alloc_en && alloc_frame == PFN_W'(f)) begin
                free_q[f]  <= 1'b0;
                owner_q[f] <= alloc_vpn;
            end
        end
    end

    always_comb begin
        low_free = '0;
        for (int f = N_FRAME - 1; f >= 0; f--)
            if (free_q[f]) low_free = PFN_W'(f);
    end

    assign any_free = |free_q;
    assign own_vpn  = owner_q[own_frame];
endmodule

// File: rtl/pgxlat_unit.sv
module pgxlat_unit
    import pgxlat_pkg::*;
#(
    parameter int VA_W  = XL_VA_W,
    parameter int OFS_W = XL_OFS_W,
    parameter int PA_W  = XL_PA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    output logic                  rsp_valid,
    output logic [PA_W-1:0]       rsp_paddr,
    output logic                  rsp_fault,
    output logic                  wb_valid,
    output logic [VA_W-OFS_W-1:0] wb_vpn,
    output logic [PA_W-OFS_W-1:0] wb_frame,
    input  logic                  wb_done,
    output logic                  fill_valid,
    output logic [VA_W-OFS_W-1:0] fill_vpn,
    output logic [PA_W-OFS_W-1:0] fill_frame,
    input  logic                  fill_done
);
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PFN_W = PA_W - OFS_W;

    xl_state_e state_q, state_d;

    logic [VPN_W-1:0] h_vpn_q, h_evict_vpn_q;
    logic [OFS_W-1:0] h_ofs_q;
    logic             h_write_q;
    logic [PFN_W-1:0] h_frame_q;

    logic [VPN_W-1:0] in_vpn;
    logic             lk_valid, lk_dirty, vic_dirty;
    logic [PFN_W-1:0] lk_frame, victim, low_free;
    logic             any_free;
    logic [VPN_W-1:0] vic_vpn;
    logic             accept, hit;
    logic             dset_en, inval_en, inst_en, touch_en;
    logic [PFN_W-1:0] touch_frame;

    assign in_vpn = req_vaddr[VA_W-1:OFS_W];

    pgxlat_table #(.VPN_W(VPN_W), .PFN_W(PFN_W)) table_i (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(in_vpn), .lk_valid(lk_valid), .lk_dirty(lk_dirty), .lk_frame(lk_frame),
        .rd_vpn(vic_vpn), .rd_dirty(vic_dirty),
        .dset_en(dset_en), .dset_vpn(in_vpn),
        .inval_en(inval_en), .inval_vpn(vic_vpn),
        .inst_en(inst_en), .inst_vpn(h_vpn_q), .inst_frame(h_frame_q), .inst_dirty(h_write_q)
    );

    pgxlat_lru #(.PFN_W(PFN_W)) lru_i (
        .clk(clk), .rst_n(rst_n),
        .touch_en(touch_en), .touch_frame(touch_frame), .victim(victim)
    );

    pgxlat_falloc #(.VPN_W(VPN_W), .PFN_W(PFN_W)) falloc_i (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(inst_en), .alloc_frame(h_frame_q), .alloc_vpn(h_vpn_q),
        .any_free(any_free), .low_free(low_free),
        .own_frame(victim), .own_vpn(vic_vpn)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control outputs
    always_comb begin
        state_d     = state_q;
        req_ready   = 1'b0;
        wb_valid    = 1'b0;
        fill_valid  = 1'b0;
        accept      = 1'b0;
        hit         = 1'b0;
        dset_en     = 1'b0;
        inval_en    = 1'b0;
        inst_en     = 1'b0;
        touch_en    = 1'b0;
        touch_frame = lk_frame;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                accept    = req_valid;
                hit       = req_valid && lk_valid;
                dset_en   = hit && req_write && !lk_dirty;
                touch_en  = hit;
                if (req_valid && !lk_valid) state_d = ST_SELECT;
            end
            ST_SELECT: begin
                inval_en = !any_free;
                if (!any_free && vic_dirty) state_d = ST_WRITEBACK;
                else                        state_d = ST_FILL;
            end
            ST_WRITEBACK: begin
                wb_valid = 1'b1;
                if (wb_done) state_d = ST_FILL;
            end
            ST_FILL: begin
                fill_valid = 1'b1;
                if (fill_done) state_d = ST_UPDATE;
            end
            ST_UPDATE: begin
                inst_en     = 1'b1;
                touch_en    = 1'b1;
                touch_frame = h_frame_q;
                state_d     = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Held request, chosen frame and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_vpn_q       <= '0;
            h_ofs_q       <= '0;
            h_write_q     <= 1'b0;
            h_frame_q     <= '0;
            h_evict_vpn_q <= '0;
            rsp_valid     <= 1'b0;
            rsp_fault     <= 1'b0;
            rsp_paddr     <= '0;
        end else begin
            if (accept) begin
                h_vpn_q   <= in_vpn;
                h_ofs_q   <= req_vaddr[OFS_W-1:0];
                h_write_q <= req_write;
            end
            if (state_q == ST_SELECT) begin
                h_frame_q     <= any_free ? low_free : victim;
                h_evict_vpn_q <= vic_vpn;
            end
            rsp_valid <= hit || (state_q == ST_UPDATE);
            rsp_fault <= (state_q == ST_UPDATE);
            if (hit)                         rsp_paddr <= {lk_frame, req_vaddr[OFS_W-1:0]};
            else if (state_q == ST_UPDATE)   rsp_paddr <= {h_frame_q, h_ofs_q};
        end
    end

    assign wb_vpn     = h_evict_vpn_q;
    assign wb_frame   = h_frame_q;
    assign fill_vpn   = h_vpn_q;
    assign fill_frame = h_frame_q;

    AST_HIT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && lk_valid) |=> (rsp_valid && !rsp_fault)); // R2
    AST_FAULT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> $past(fill_valid && fill_done, 2)); // R3
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_done) |=> (wb_valid && $stable(wb_vpn) && $stable(wb_frame))); // R7
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_done) |=> (fill_valid && $stable(fill_vpn) && $stable(fill_frame))); // R10
    AST_NO_READY_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> !rsp_valid); // R11
endmodule

// File: tb/pgxlat_unit_tb.sv
module pgxlat_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [4:0] req_vaddr = '0;
    logic       req_write = 1'b0;
    logic       rsp_valid;
    logic [3:0] rsp_paddr;
    logic       rsp_fault;
    logic       wb_valid;
    logic [2:0] wb_vpn;
    logic [1:0] wb_frame;
    logic       wb_done = 1'b0;
    logic       fill_valid;
    logic [2:0] fill_vpn;
    logic [1:0] fill_frame;
    logic       fill_done = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    pgxlat_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .wb_valid(wb_valid), .wb_vpn(wb_vpn), .wb_frame(wb_frame), .wb_done(wb_done),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame), .fill_done(fill_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One access; for faults, exp_frame is the frame filled and wb_* the expected eviction
    task automatic access(input logic [4:0] va, input bit wr, input bit exp_fault,
                          input logic [3:0] exp_pa, input bit exp_wb,
                          input logic [2:0] exp_wbv, input logic [1:0] exp_wbf,
                          input string req);
        bit seen_wb = 1'b0;
        bit done = 1'b0;
        int guard = 0;
        chk(req_ready == 1'b1, "R11", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!exp_fault) begin
            chk(rsp_valid && !rsp_fault, req, "hit response flags",
                int'({rsp_valid, rsp_fault}), 2);
            chk(rsp_paddr == exp_pa, req, "hit paddr", int'(rsp_paddr), int'(exp_pa));
            return;
        end
        chk(!rsp_valid && !req_ready, "R11", "stall after miss",
            int'({rsp_valid, req_ready}), 0);
        while (!done && guard < 40) begin
            guard++;
            if (wb_valid) begin
                seen_wb = 1'b1;
                chk(wb_vpn == exp_wbv, "R7", "wb vpn", int'(wb_vpn), int'(exp_wbv));
                chk(wb_frame == exp_wbf, "R7", "wb frame", int'(wb_frame), int'(exp_wbf));
                @(negedge clk);
                chk(wb_valid && wb_vpn == exp_wbv && wb_frame == exp_wbf && !req_ready,
                    "R7", "wb held", int'(wb_valid), 1);
                wb_done = 1'b1;
                @(negedge clk);
                wb_done = 1'b0;
            end else if (fill_valid) begin
                chk(fill_vpn == va[4:2], "R10", "fill vpn", int'(fill_vpn), int'(va[4:2]));
                chk(fill_frame == exp_pa[3:2], "R10", "fill frame",
                    int'(fill_frame), int'(exp_pa[3:2]));
                @(negedge clk);
                chk(fill_valid && fill_vpn == va[4:2] && fill_frame == exp_pa[3:2],
                    "R10", "fill held", int'(fill_valid), 1);
                fill_done = 1'b1;
                @(negedge clk);
                fill_done = 1'b0;
                chk(!rsp_valid && !req_ready, "R3", "update cycle silent",
                    int'({rsp_valid, req_ready}), 0);
                @(negedge clk);
                chk(rsp_valid && rsp_fault, "R3", "fault response flags",
                    int'({rsp_valid, rsp_fault}), 3);
                chk(rsp_paddr == exp_pa, req, "fault paddr", int'(rsp_paddr), int'(exp_pa));
                done = 1'b1;
            end else begin
                @(negedge clk);
            end
        end
        chk(done, req, "fault sequence completed", int'(done), 1);
        chk(seen_wb == exp_wb, "R7", "write-back presence", int'(seen_wb), int'(exp_wb));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(req_ready && !rsp_valid && !wb_valid && !fill_valid, "R1", "reset outputs",
            int'({req_ready, rsp_valid, wb_valid, fill_valid}), 8);
    endtask

    task automatic t_free_frames();
        access(5'b01001, 1'b0, 1'b1, 4'b0001, 1'b0, 3'd0, 2'd0, "R4");  // page2 -> f0
        access(5'b10110, 1'b1, 1'b1, 4'b0110, 1'b0, 3'd0, 2'd0, "R4");  // page5 -> f1, dirty
    endtask

    task automatic t_hits();
        access(5'b01011, 1'b0, 1'b0, 4'b0011, 1'b0, 3'd0, 2'd0, "R5");  // page2 again
        access(5'b10101, 1'b0, 1'b0, 4'b0101, 1'b0, 3'd0, 2'd0, "R2");  // page5 read hit
        access(5'b01000, 1'b0, 1'b0, 4'b0000, 1'b0, 3'd0, 2'd0, "R2");  // page2 re-touch
        access(5'b00011, 1'b0, 1'b1, 4'b1011, 1'b0, 3'd0, 2'd0, "R4");  // page0 -> f2
        access(5'b11100, 1'b0, 1'b1, 4'b1100, 1'b0, 3'd0, 2'd0, "R4");  // page7 -> f3
    endtask

    task automatic t_evict_dirty();
        // recency f3,f2,f0,f1: victim f1 holding dirty page5
        access(5'b00101, 1'b0, 1'b1, 4'b0101, 1'b1, 3'd5, 2'd1, "R6");
    endtask

    task automatic t_refault();
        // page5 invalidated; recency f1,f3,f2,f0: victim f0 (page2 clean)
        access(5'b10100, 1'b0, 1'b1, 4'b0000, 1'b0, 3'd0, 2'd0, "R8");
    endtask

    task automatic t_dirty_track();
        access(5'b00001, 1'b1, 1'b0, 4'b1001, 1'b0, 3'd0, 2'd0, "R9");  // write hit page0 f2
        // recency f2,f0,f1,f3
        access(5'b01100, 1'b0, 1'b1, 4'b1100, 1'b0, 3'd0, 2'd0, "R6");  // evict p7 f3 clean
        access(5'b11000, 1'b0, 1'b1, 4'b0100, 1'b0, 3'd0, 2'd0, "R9");  // evict p1 f1 read-only
        access(5'b01000, 1'b0, 1'b1, 4'b0000, 1'b0, 3'd0, 2'd0, "R6");  // evict p5 f0 clean
        access(5'b10011, 1'b0, 1'b1, 4'b1011, 1'b1, 3'd0, 2'd2, "R9");  // evict p0 f2 dirty
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_free_frames();
        t_hits();
        t_evict_dirty();
        t_refault();
        t_dirty_track();
        repeat (2) @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule